// File: doc/BRIEF.md
# T1 Extended Superframe Alignment Tracker

This block recovers and then holds the 24-frame extended superframe phase of a T1 line. An upstream frame delineator hands over one F-bit per 193-bit frame with a strobe. The tracker tests all 24 possible phases of the superframe at once. For each phase it counts how many consecutive superframes carried the framing pattern intact. It declares alignment when a phase becomes definite under the selected rule. Once aligned, it numbers each frame, pulses a strobe per frame and another at frame 1. It also watches the framing bits against a loss criterion chosen by software.

Two controls let a controller steer the search. A resync request drops alignment and restarts the search from an empty memory. A lock request makes the tracker take the next phase that completes one clean superframe. CRC6 errors come from an external checker as single-cycle pulses. Together with a one-second tick they can form an extra loss condition.

Top module: `esf_msync`

## Requirements
- R1: After reset, in_sync is 0, frame_num is 0, and frame_start and mf_start are low. While out of sync, frame_num stays 0 and both strobes stay low.
- R2: The framing bits sit in frames 4, 8, 12, 16, 20 and 24 (frame_num multiple of 4) and carry 0,0,1,0,1,1 in that order. Bits in all other frames have no effect on search or loss.
- R3: With mode_sel=1, a phase that carries the pattern intact over three full consecutive superframes is taken. A partial superframe seen at the start of the search does not count. in_sync rises in the cycle after the frame-24 bit that completes the third superframe, and frame_num then reads 24.
- R4: With mode_sel=0, alignment is taken only when the completing phase reaches three clean superframes and every other phase has a count of zero. If a second phase keeps matching, in_sync stays 0.
- R5: While in sync, each F-bit strobe advances frame_num by one, from 24 back to 1, in the following cycle. frame_start pulses for one cycle per F-bit, and mf_start pulses together with frame_num=1.
- R6: loss_sel=0, 1 or 2 drops sync when two framing-bit errors fall within a window of 4, 5 or 6 framing bits, counting the one just received. in_sync falls in the cycle after the second error.
- R7: loss_sel=3 drops sync when a second framing-bit error falls within the same superframe (frames 1 to 24).
- R8: Four consecutive superframes that each contain at least one framing-bit error drop sync after the frame-24 bit of the fourth, whatever the loss_sel setting.
- R9: With crc_loss_en=1, sync drops in the cycle after a sec_tick if more than CRC_LIM crc_err pulses arrived since the previous tick. The count clears on every tick. With crc_loss_en=0, crc_err has no effect.
- R10: In sync, a pulse on force_resync or loss_req drops in_sync in the next cycle and empties the phase memory. A new alignment then needs three more full superframes.
- R11: Out of sync, a force_lock pulse arms a lock onto the first phase that completes one clean full superframe. The lock clears the phase memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fbit | input | 1 | F-bit of the current frame |
| fbit_vld | input | 1 | One-cycle strobe qualifying fbit |
| crc_err | input | 1 | One pulse per superframe CRC6 mismatch |
| sec_tick | input | 1 | One-second interval tick |
| mode_sel | input | 1 | 0: unique-phase rule, 1: three-superframe rule |
| loss_sel | input | 2 | Loss criterion: 0/1/2 windows of 4/5/6, 3 per superframe |
| crc_loss_en | input | 1 | Enables the CRC6 rate loss condition |
| force_resync | input | 1 | Drop alignment and restart the search |
| loss_req | input | 1 | External request to drop alignment |
| force_lock | input | 1 | Lock onto the next available phase |
| in_sync | output | 1 | Alignment held |
| frame_num | output | 5 | Frame number 1..24 of the last F-bit, 0 out of sync |
| frame_start | output | 1 | One pulse per F-bit while aligned |
| mf_start | output | 1 | Pulse when frame_num becomes 1 |

## Verification
The bench builds the tracker with CRC_LIM=20 and keeps the other defaults. This puts the CRC threshold and its neighbours (20, 21, and two bursts of 15 split by a tick) within a few dozen pulses. It sweeps every loss_sel setting against error separations of 1 to 7 framing bits, so each window edge is crossed from both sides. A second phase is planted in the data frames. With it, the bench shows that the unique rule refuses to lock, that force_lock takes the earlier-completing phase, and that the exact lock bit follows the count of full superframes.

// File: rtl/esf_pkg.sv
package esf_pkg;
  localparam int MF_LEN   = 24;
  localparam int FAS_NUM  = 6;
  localparam int PW       = $clog2(MF_LEN);
  localparam int FW       = $clog2(MF_LEN + 1);
  // framing pattern, bit k is the value at framing slot k (frames 4..24)
  localparam logic [7:0] FAS_PAT = 8'b0011_0100;

  function automatic logic fas_slot(input logic [1:0] lo);
    return lo == 2'b11;
  endfunction

  function automatic logic fas_val(input logic [2:0] slot);
    return FAS_PAT[slot];
  endfunction
endpackage

// File: rtl/esf_cand_mem.sv
module esf_cand_mem
  import esf_pkg::*;
#(
  parameter int DEF_CNT = 3,
  localparam int CW = $clog2(DEF_CNT + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          vld,
  input  logic          fbit,
  output logic [CW-1:0] end_cnt_d,
  output logic          others_idle
);
  logic [PW-1:0] ph_q;
  logic [CW-1:0] cnt_q [MF_LEN];
  logic [CW-1:0] cnt_d [MF_LEN];
  logic [MF_LEN-1:0] clean_q, clean_d;
  logic [PW-1:0] end_idx;
  logic any_cnt;

  assign end_idx = PW'(MF_LEN - 1) - ph_q;

  always_ff @(posedge clk) begin
    if (rst) ph_q <= '0;
    else if (vld) ph_q <= (ph_q == PW'(MF_LEN - 1)) ? '0 : ph_q + 1'b1;
  end

  always_comb begin
    clean_d = clean_q;
    for (int j = 0; j < MF_LEN; j++) begin
      logic [PW-1:0] fj;
      logic hit;
      fj = PW'((32'(ph_q) + j) % MF_LEN);
      hit = (fbit == fas_val(fj[4:2]));
      cnt_d[j] = cnt_q[j];
      if (vld && fas_slot(fj[1:0])) begin
        if (fj == PW'(MF_LEN - 1)) begin
          clean_d[j] = 1'b1;
          if (clean_q[j] && hit)
            cnt_d[j] = (cnt_q[j] == CW'(DEF_CNT)) ? cnt_q[j] : cnt_q[j] + 1'b1;
          else
            cnt_d[j] = '0;
        end else if (!hit) begin
          clean_d[j] = 1'b0;
          cnt_d[j]   = '0;
        end
      end
    end
  end

  always_comb begin
    others_idle = 1'b1;
    any_cnt     = 1'b0;
    for (int j = 0; j < MF_LEN; j++) begin
      if (PW'(j) != end_idx && cnt_d[j] != '0) others_idle = 1'b0;
      if (cnt_q[j] != '0) any_cnt = 1'b1;
    end
    end_cnt_d = cnt_d[end_idx];
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      for (int j = 0; j < MF_LEN; j++) cnt_q[j] <= '0;
      clean_q <= '0;
    end else begin
      cnt_q   <= cnt_d;
      clean_q <= clean_d;
    end
  end

  AST_CLR_EMPTY: assert property (@(posedge clk) disable iff (rst) clr |=> !any_cnt); // R10
endmodule

// File: rtl/esf_loss_mon.sv
module esf_loss_mon
  import esf_pkg::*;
#(
  parameter int CRC_LIM    = 320,
  parameter int BAD_MF_LIM = 4,
  localparam int CCW = $clog2(CRC_LIM + 2),
  localparam int BW  = $clog2(BAD_MF_LIM)
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       clr,
  input  logic       fas_vld,
  input  logic       fas_err,
  input  logic       mf_end,
  input  logic [1:0] sel,
  input  logic       crc_en,
  input  logic       crc_err,
  input  logic       sec_tick,
  output logic       loss
);
  logic [FAS_NUM-1:0] hist_q, win, mask;
  logic               mf_err_q, mf_bad;
  logic [BW-1:0]      bad_q;
  logic [CCW-1:0]     crc_q;
  logic               loss_win, loss_mf, loss_bad, loss_crc;

  assign win = {hist_q[FAS_NUM-2:0], fas_err};

  always_comb begin
    case (sel)
      2'd0:    mask = FAS_NUM'(4'hF);
      2'd1:    mask = FAS_NUM'(5'h1F);
      default: mask = '1;
    endcase
  end

  assign mf_bad   = mf_err_q || fas_err;
  assign loss_win = fas_vld && fas_err && (sel != 2'd3) && ($countones(win & mask) >= 2);
  assign loss_mf  = fas_vld && fas_err && (sel == 2'd3) && mf_err_q;
  assign loss_bad = fas_vld && mf_end && mf_bad && (bad_q == BW'(BAD_MF_LIM - 1));
  assign loss_crc = sec_tick && crc_en && (crc_q > CCW'(CRC_LIM));
  assign loss     = loss_win || loss_mf || loss_bad || loss_crc;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      hist_q   <= '0;
      mf_err_q <= 1'b0;
      bad_q    <= '0;
      crc_q    <= '0;
    end else begin
      if (fas_vld) begin
        hist_q   <= win;
        mf_err_q <= mf_end ? 1'b0 : mf_bad;
        if (mf_end)
          bad_q <= !mf_bad ? '0 :
                   (bad_q == BW'(BAD_MF_LIM - 1)) ? bad_q : bad_q + 1'b1;
      end
      if (sec_tick) crc_q <= '0;
      else if (crc_err && crc_q != CCW'(CRC_LIM + 1)) crc_q <= crc_q + 1'b1;
    end
  end

  AST_CRC_TICK_CLR: assert property (@(posedge clk) disable iff (rst) sec_tick |=> crc_q == '0); // R9
  AST_MF_FRESH: assert property (@(posedge clk) disable iff (rst) (fas_vld && mf_end) |=> !mf_err_q); // R7
endmodule

// File: rtl/esf_msync.sv
module esf_msync
  import esf_pkg::*;
#(
  parameter int DEF_CNT    = 3,
  parameter int CRC_LIM    = 320,
  parameter int BAD_MF_LIM = 4,
  localparam int CW = $clog2(DEF_CNT + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          fbit,
  input  logic          fbit_vld,
  input  logic          crc_err,
  input  logic          sec_tick,
  input  logic          mode_sel,
  input  logic [1:0]    loss_sel,
  input  logic          crc_loss_en,
  input  logic          force_resync,
  input  logic          loss_req,
  input  logic          force_lock,
  output logic          in_sync,
  output logic [FW-1:0] frame_num,
  output logic          frame_start,
  output logic          mf_start
);
  logic [CW-1:0] end_cnt_d;
  logic          others_idle, mon_loss, lock_arm_q;
  logic [FW-1:0] frm_nxt, frm_idx;
  logic          fas_vld, fas_err, mf_end, drop, take, cand_clr;

  assign frm_nxt = (frame_num == FW'(MF_LEN)) ? FW'(1) : frame_num + 1'b1;
  assign frm_idx = frm_nxt - 1'b1;
  assign fas_vld = in_sync && fbit_vld && fas_slot(frm_idx[1:0]);
  assign fas_err = fbit != fas_val(frm_idx[4:2]);
  assign mf_end  = frm_nxt == FW'(MF_LEN);
  assign drop    = in_sync && (mon_loss || force_resync || loss_req);

  always_comb begin
    take = 1'b0;
    if (!in_sync && fbit_vld && !force_resync) begin
      if (lock_arm_q || force_lock) take = end_cnt_d != '0;
      else if (mode_sel)            take = end_cnt_d == CW'(DEF_CNT);
      else                          take = (end_cnt_d == CW'(DEF_CNT)) && others_idle;
    end
  end

  assign cand_clr = in_sync || take || force_resync;

  esf_cand_mem #(.DEF_CNT(DEF_CNT)) u_cand (
    .clk(clk), .rst(rst), .clr(cand_clr), .vld(fbit_vld && !in_sync), .fbit(fbit),
    .end_cnt_d(end_cnt_d), .others_idle(others_idle)
  );

  esf_loss_mon #(.CRC_LIM(CRC_LIM), .BAD_MF_LIM(BAD_MF_LIM)) u_loss (
    .clk(clk), .rst(rst), .clr(!in_sync), .fas_vld(fas_vld), .fas_err(fas_err),
    .mf_end(mf_end), .sel(loss_sel), .crc_en(crc_loss_en), .crc_err(crc_err),
    .sec_tick(sec_tick), .loss(mon_loss)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      in_sync     <= 1'b0;
      frame_num   <= '0;
      frame_start <= 1'b0;
      mf_start    <= 1'b0;
      lock_arm_q  <= 1'b0;
    end else begin
      frame_start <= 1'b0;
      mf_start    <= 1'b0;
      if (drop) begin
        in_sync   <= 1'b0;
        frame_num <= '0;
      end else if (in_sync && fbit_vld) begin
        frame_num   <= frm_nxt;
        frame_start <= 1'b1;
        mf_start    <= frm_nxt == FW'(1);
      end else if (take) begin
        in_sync     <= 1'b1;
        frame_num   <= FW'(MF_LEN);
        frame_start <= 1'b1;
      end
      if (in_sync || take) lock_arm_q <= 1'b0;
      else if (force_lock) lock_arm_q <= 1'b1;
    end
  end

  AST_LOCK_AT_END: assert property (@(posedge clk) disable iff (rst) $rose(in_sync) |-> frame_num == FW'(MF_LEN)); // R3
  AST_FRAME_ADV: assert property (@(posedge clk) disable iff (rst)
    (in_sync && $past(in_sync) && frame_start) |->
    frame_num == (($past(frame_num) == FW'(MF_LEN)) ? FW'(1) : FW'($past(frame_num) + 1'b1))); // R5
  AST_MF_AT_ONE: assert property (@(posedge clk) disable iff (rst) mf_start |-> (frame_num == FW'(1) && frame_start)); // R5
  AST_IDLE_OUT: assert property (@(posedge clk) disable iff (rst) !in_sync |-> (frame_num == '0 && !frame_start && !mf_start)); // R1
  AST_REQ_DROP: assert property (@(posedge clk) disable iff (rst) (in_sync && (force_resync || loss_req)) |=> !in_sync); // R10
  AST_LOSS_DROP: assert property (@(posedge clk) disable iff (rst) (in_sync && mon_loss) |=> !in_sync); // R6
endmodule

// File: tb/tb_esf_msync.sv
module tb_esf_msync;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic fbit = 1'b0, fbit_vld = 1'b0, crc_err = 1'b0, sec_tick = 1'b0;
  logic mode_sel = 1'b1, crc_loss_en = 1'b0;
  logic force_resync = 1'b0, loss_req = 1'b0, force_lock = 1'b0;
  logic [1:0] loss_sel = 2'd0;
  logic in_sync, frame_start, mf_start;
  logic [4:0] frame_num;

  int nchk = 0, nfail = 0;
  int fi = 0;
  bit fill = 1'b1, fake = 1'b0;

  always #10 clk = ~clk;

  esf_msync #(.CRC_LIM(20)) dut (
    .clk(clk), .rst(rst), .fbit(fbit), .fbit_vld(fbit_vld), .crc_err(crc_err),
    .sec_tick(sec_tick), .mode_sel(mode_sel), .loss_sel(loss_sel),
    .crc_loss_en(crc_loss_en), .force_resync(force_resync), .loss_req(loss_req),
    .force_lock(force_lock), .in_sync(in_sync), .frame_num(frame_num),
    .frame_start(frame_start), .mf_start(mf_start)
  );

  task automatic chk(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s act=%0d exp=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic bit pat(input int f);
    return bit'((6'b110100 >> (f / 4)) & 1);
  endfunction

  function automatic bit sbit(input int f);
    if (f % 4 == 3) return pat(f);
    if (fake && (f % 4 == 0)) return pat((f + 3) % 24);
    return fill;
  endfunction

  function automatic int last_frame();
    return ((fi + 23) % 24) + 1;
  endfunction

  task automatic send(input bit b);
    @(negedge clk); fbit = b; fbit_vld = 1'b1;
    @(negedge clk); fbit_vld = 1'b0;
    fi = (fi + 1) % 24;
  endtask

  task automatic send_std();
    send(sbit(fi));
  endtask

  task automatic do_resync();
    @(negedge clk); force_resync = 1'b1;
    @(negedge clk); force_resync = 1'b0;
  endtask

  task automatic relock(output int n);
    n = 0;
    if (in_sync) do_resync();
    while (!in_sync && n < 200) begin send_std(); n++; end
    chk("R3 relock", in_sync, 1);
    chk("R3 relock frame", frame_num, 24);
  endtask

  task automatic crc_burst(input int n);
    repeat (n) begin
      @(negedge clk); crc_err = 1'b1;
      @(negedge clk); crc_err = 1'b0;
    end
  endtask

  task automatic tick();
    @(negedge clk); sec_tick = 1'b1;
    @(negedge clk); sec_tick = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nfail++;
    $display("FAIL R1 watchdog act=running exp=finished");
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    int n;
    repeat (4) @(negedge clk);
    chk("R1 in_sync", in_sync, 0);
    chk("R1 frame_num", frame_num, 0);
    chk("R1 strobes", {frame_start, mf_start}, 0);
    rst = 1'b0;

    // R3: exact lock bit, partial superframe not counted
    repeat (95) send_std();
    chk("R3 before lock", in_sync, 0);
    chk("R1 idle frame_num", frame_num, 0);
    send_std();
    chk("R3 lock", in_sync, 1);
    chk("R3 frame 24", frame_num, 24);

    // R5: frame counting and strobes
    for (int k = 0; k < 48; k++) begin
      send_std();
      chk("R5 frame_num", frame_num, last_frame());
      chk("R5 frame_start", frame_start, 1);
      chk("R5 mf_start", mf_start, int'(last_frame() == 1));
    end
    @(negedge clk);
    chk("R5 frame_start one cycle", frame_start, 0);

    // R2: data frames ignored in sync and during search
    fill = 1'b0;
    repeat (48) send_std();
    chk("R2 fill0 in sync", in_sync, 1);
    relock(n);
    chk("R2 fill0 lock bits", n, 96);
    fill = 1'b1;

    // R6/R7: sweep loss criteria against error separation
    for (int sel = 0; sel < 4; sel++) begin
      for (int d = 1; d < 8; d++) begin
        int fas_n;
        bit exp_loss;
        loss_sel = 2'(sel);
        relock(n);
        repeat (3) send_std();
        fas_n = 0;
        forever begin
          bit b, last;
          b = sbit(fi);
          last = 1'b0;
          if (fi % 4 == 3) begin
            if (fas_n == 0 || fas_n == d) b = ~b;
            last = (fas_n == d);
            fas_n++;
          end
          send(b);
          if (last) break;
        end
        exp_loss = (sel < 3) ? (d <= 3 + sel) : (d <= 5);
        if (sel < 3) chk($sformatf("R6 sel%0d d%0d", sel, d), in_sync, int'(!exp_loss));
        else         chk($sformatf("R7 d%0d", d), in_sync, int'(!exp_loss));
        if (!exp_loss) begin
          repeat (24) send_std();
          chk("R6 R7 holds", in_sync, 1);
        end
      end
    end

    // R8: four consecutive bad superframes
    loss_sel = 2'd2;
    relock(n);
    for (int m = 0; m < 4; m++) begin
      repeat (24) begin
        bit b;
        b = sbit(fi);
        if (fi == 3) b = ~b;
        send(b);
      end
      chk($sformatf("R8 mf%0d", m), in_sync, int'(m < 3));
    end

    // R9: CRC error rate
    relock(n);
    crc_loss_en = 1'b1;
    crc_burst(20); tick();
    chk("R9 at limit", in_sync, 1);
    crc_burst(21); tick();
    chk("R9 over limit", in_sync, 0);
    relock(n);
    crc_burst(15); tick(); crc_burst(15); tick();
    chk("R9 clear on tick", in_sync, 1);
    crc_loss_en = 1'b0;
    crc_burst(25); tick();
    chk("R9 disabled", in_sync, 1);

    // R10: loss request and search restart
    relock(n);
    @(negedge clk); loss_req = 1'b1;
    @(negedge clk); loss_req = 1'b0;
    chk("R10 loss_req drop", in_sync, 0);
    n = 0;
    while (!in_sync && n < 200) begin send_std(); n++; end
    chk("R10 restart bits", n, 96);

    // R4: unique-phase rule with a competing phase
    mode_sel = 1'b0;
    fake = 1'b1;
    do_resync();
    chk("R10 force_resync drop", in_sync, 0);
    repeat (144) send_std();
    chk("R4 ambiguous stays out", in_sync, 0);
    fake = 1'b0;
    n = 0;
    while (!in_sync && n < 48) begin send_std(); n++; end
    chk("R4 unique lock", in_sync, 1);
    chk("R4 true phase", frame_num, last_frame());

    // R11: forced lock onto the next available phase
    mode_sel = 1'b1;
    relock(n);
    fake = 1'b1;
    do_resync();
    @(negedge clk); force_lock = 1'b1;
    @(negedge clk); force_lock = 1'b0;
    n = 0;
    while (!in_sync && n < 100) begin send_std(); n++; end
    chk("R11 lock bits", n, 45);
    chk("R11 frame", frame_num, 24);
    send_std();
    chk("R11 tracks phase", frame_num, 1);
    fake = 1'b0;

    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule